// File: doc/BRIEF.md
# Flash Erase Block Select Registers

This block holds the selection of the one flash block that may be erased, and it controls who may write the erase control bits. Twelve block-select bits are kept in two byte-wide registers. A low register at address 0 holds blocks 0 to 3. A high register at address 1 holds blocks 4 to 11. Software writes the registers through a simple strobe-based port. The block drives a 12-bit erase-permit vector that the erase sequencer uses, and a flag that says whether exactly one block is chosen.

The selection is wiped whenever protection is in force:

- the part is in standby,
- the hardware write-protect input is high, or
- the software write-enable bit is clear.

While the on-chip flash is disabled, both registers read as zero and ignore writes.

The block also watches the total number of selected blocks across both registers. When that count is above one, it refuses every write request for the two erase-setup bits and the two erase-enable bits.

Top module: `erase_blk_sel`

## Requirements
- R1: When rst_n is sampled low at a clock edge, all select bits become 0: erase_permit_o reads 0x000 and both registers read 0x00.
- R2: The low register (bus_addr_i = 0) stores bus_wdata_i[3:0] as blocks 0..3. Its bits 7:4 always read 0.
- R3: The high register (bus_addr_i = 1) stores all eight bits of bus_wdata_i as blocks 4..11, and reads them back unchanged.
- R4: A clock edge with standby_i high clears every select bit. A bus write in that same cycle is lost.
- R5: A clock edge with wp_pin_i high clears every select bit. A bus write in that same cycle is lost.
- R6: A clock edge with sw_wen_i low clears every select bit. A bus write in that same cycle is lost.
- R7: While flash_en_i is low, bus_rdata_o is 0x00 for both addresses, and a bus write leaves the stored selection unchanged.
- R8: erase_permit_o[i] is the select bit of block i. Bits 3:0 come from low register bits 3:0, and bits 11:4 come from high register bits 7:0.
- R9: sel_valid_o is 1 exactly when one select bit is set across both registers.
- R10: ctl_wr_grant_o equals ctl_wr_req_i when at most one select bit is set, and is 0 when two or more are set. The request and grant bit order is setup0, setup1, enable0, enable1 from bit 0 upward.
- R11: A bus write takes effect at the clock edge where bus_wr_i is high. Reads are combinational from the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| standby_i | input | 1 | Standby mode indication; clears the selection |
| wp_pin_i | input | 1 | Hardware write-protect; high clears the selection |
| sw_wen_i | input | 1 | Software write-enable bit; low clears the selection |
| flash_en_i | input | 1 | On-chip flash enabled |
| bus_wr_i | input | 1 | One-cycle write strobe |
| bus_addr_i | input | 1 | Register select: 0 = low register, 1 = high register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| ctl_wr_req_i | input | 4 | Write requests for setup0, setup1, enable0, enable1 |
| ctl_wr_grant_o | output | 4 | Write requests that are allowed through |
| erase_permit_o | output | 12 | Per-block erase permit |
| sel_valid_o | output | 1 | Exactly one block is selected |

## Verification
A lost or stuck select bit shows at erase_permit_o in the cycle after the write or clear edge. The same fault shows on bus_rdata_o at once when that register is addressed.

A wrong count of set bits shows at once in two places: sel_valid_o, and grants leaking through or being withheld for requests made in the same cycle.

A clear condition that loses priority to a bus write leaves a nonzero permit one edge later. The directed scenarios sample exactly there.

// File: rtl/erase_blk_sel_pkg.sv
// Package: shared sizes for the erase block select registers.
// Assumes one bus byte per register and a fixed split of blocks between the two registers.
package erase_blk_sel_pkg;
    localparam int unsigned BUS_W   = 8;   // register width on the bus
    localparam int unsigned LO_BLKS = 4;   // blocks held in the low register
    localparam int unsigned HI_BLKS = 8;   // blocks held in the high register
    localparam int unsigned CTL_N   = 4;   // guarded control bits: setup0, setup1, enable0, enable1
    localparam int unsigned ALL_BLKS = LO_BLKS + HI_BLKS;
endpackage

// File: rtl/sel_reg_bank.sv
// Module: one bank of select bits.
// The clear condition wins over a write in the same cycle.
// Assumes a synchronous active-low reset.
module sel_reg_bank #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    // Hold, clear or load the select bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (clr)   q <= '0;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/sel_count.sv
// Module: classifies a select vector as exactly-one or more-than-one.
// Assumes N is small enough for a plain adder chain.
module sel_count #(
    parameter int unsigned N = 12
) (
    input  logic [N-1:0] vec,
    output logic         one,
    output logic         multi
);
    localparam int unsigned CW = $clog2(N + 1);

    logic [CW-1:0] cnt;

    // Population count of the select vector.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) cnt = cnt + CW'(vec[i]);
    end

    // Classification of the count.
    always_comb begin
        one   = (cnt == CW'(1));
        multi = (cnt > CW'(1));
    end
endmodule

// File: rtl/erase_blk_sel.sv
// Module: flash erase block select registers with an interlock on the erase control bits.
// Holds twelve select bits in two byte registers and clears them under protection.
// Vetoes all control-bit writes when more than one block is selected.
// Assumes a synchronous active-low reset and a one-cycle write strobe.
module erase_blk_sel
    import erase_blk_sel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                standby_i,
    input  logic                wp_pin_i,
    input  logic                sw_wen_i,
    input  logic                flash_en_i,
    input  logic                bus_wr_i,
    input  logic                bus_addr_i,
    input  logic [BUS_W-1:0]    bus_wdata_i,
    output logic [BUS_W-1:0]    bus_rdata_o,
    input  logic [CTL_N-1:0]    ctl_wr_req_i,
    output logic [CTL_N-1:0]    ctl_wr_grant_o,
    output logic [ALL_BLKS-1:0] erase_permit_o,
    output logic                sel_valid_o
);
    logic                clr;
    logic                wr_lo, wr_hi;
    logic [LO_BLKS-1:0]  lo_q;
    logic [HI_BLKS-1:0]  hi_q;
    logic                multi;

    // Protection clear: standby, hardware protect, or software enable off.
    always_comb clr = standby_i | wp_pin_i | ~sw_wen_i;

    // Address decode; writes count only while the flash is enabled.
    always_comb begin
        wr_lo = bus_wr_i & flash_en_i & ~bus_addr_i;
        wr_hi = bus_wr_i & flash_en_i &  bus_addr_i;
    end

    sel_reg_bank #(.WIDTH(LO_BLKS)) i_lo (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_lo),
        .wdata(bus_wdata_i[LO_BLKS-1:0]), .q(lo_q)
    );

    sel_reg_bank #(.WIDTH(HI_BLKS)) i_hi (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_hi),
        .wdata(bus_wdata_i[HI_BLKS-1:0]), .q(hi_q)
    );

    // Block i of the permit vector follows its select bit.
    always_comb erase_permit_o = {hi_q, lo_q};

    sel_count #(.N(ALL_BLKS)) i_cnt (
        .vec(erase_permit_o), .one(sel_valid_o), .multi(multi)
    );

    // Interlock: no control-bit writes with an ambiguous selection.
    always_comb ctl_wr_grant_o = multi ? '0 : ctl_wr_req_i;

    // Read mux; the unused low-register bits read zero, and the whole read is zero while flash is off.
    always_comb begin
        if (!flash_en_i)     bus_rdata_o = '0;
        else if (bus_addr_i) bus_rdata_o = BUS_W'(hi_q);
        else                 bus_rdata_o = BUS_W'(lo_q);
    end
endmodule

// File: rtl/erase_blk_sel_chk.sv
// Module: assertion checker for erase_blk_sel, attached by bind.
// Observes ports only.
module erase_blk_sel_chk
    import erase_blk_sel_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                standby_i,
    input logic                wp_pin_i,
    input logic                sw_wen_i,
    input logic                flash_en_i,
    input logic                bus_addr_i,
    input logic [BUS_W-1:0]    bus_rdata_o,
    input logic [CTL_N-1:0]    ctl_wr_req_i,
    input logic [CTL_N-1:0]    ctl_wr_grant_o,
    input logic [ALL_BLKS-1:0] erase_permit_o,
    input logic                sel_valid_o
);
    p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> erase_permit_o == '0);
    p_lo_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr_i |-> bus_rdata_o[BUS_W-1:LO_BLKS] == '0);
    p_standby_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> erase_permit_o == '0);
    p_wp_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wp_pin_i |=> erase_permit_o == '0);
    p_swen_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wen_i |=> erase_permit_o == '0);
    p_rd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_en_i |-> bus_rdata_o == '0);
    p_wr_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_en_i && !standby_i && !wp_pin_i && sw_wen_i) |=> $stable(erase_permit_o));
    p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o == ($countones(erase_permit_o) == 1));
    p_veto_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(erase_permit_o) > 1) |-> ctl_wr_grant_o == '0);
    p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(erase_permit_o) <= 1) |-> ctl_wr_grant_o == ctl_wr_req_i);
endmodule

bind erase_blk_sel erase_blk_sel_chk i_chk (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .wp_pin_i(wp_pin_i),
    .sw_wen_i(sw_wen_i), .flash_en_i(flash_en_i), .bus_addr_i(bus_addr_i),
    .bus_rdata_o(bus_rdata_o), .ctl_wr_req_i(ctl_wr_req_i),
    .ctl_wr_grant_o(ctl_wr_grant_o), .erase_permit_o(erase_permit_o),
    .sel_valid_o(sel_valid_o)
);

// File: tb/test_erase_blk_sel.sv
`timescale 1ns/1ps
// Directed bench for erase_blk_sel. Inputs change at the falling edge and outputs are sampled there.
module test_erase_blk_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_i = 1'b0, wp_pin_i = 1'b0, sw_wen_i = 1'b1, flash_en_i = 1'b1;
    logic        bus_wr_i = 1'b0, bus_addr_i = 1'b0;
    logic [7:0]  bus_wdata_i = 8'h00;
    logic [7:0]  bus_rdata_o;
    logic [3:0]  ctl_wr_req_i = 4'h0;
    logic [3:0]  ctl_wr_grant_o;
    logic [11:0] erase_permit_o;
    logic        sel_valid_o;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    erase_blk_sel i_erase_blk_sel (.*);

    // Compare one value and report a mismatch.
    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write strobe; the result is visible at the next falling edge.
    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    // Combinational read of one register.
    task automatic read_chk(input string tag, input logic a, input logic [7:0] exp);
        bus_addr_i = a; #1;
        check(tag, {8'h0, bus_rdata_o}, {8'h0, exp});
    endtask

    task automatic t_reset;
        check("R1 permit", {4'h0, erase_permit_o}, 16'h0);
        read_chk("R1 lo", 1'b0, 8'h00);
        read_chk("R1 hi", 1'b1, 8'h00);
        check("R1 valid", {15'h0, sel_valid_o}, 16'h0);
    endtask

    task automatic t_low_reg;
        bus_write(1'b0, 8'hFF);
        read_chk("R2 lo read", 1'b0, 8'h0F);
        check("R8 permit lo", {4'h0, erase_permit_o}, 16'h000F);
        bus_write(1'b0, 8'h00);
    endtask

    task automatic t_high_reg;
        bus_write(1'b1, 8'hA5);
        read_chk("R3 hi read", 1'b1, 8'hA5);
        check("R8 permit hi", {4'h0, erase_permit_o}, 16'h0A50);
        check("R11 write lands next edge", {15'h0, sel_valid_o}, 16'h0);
    endtask

    task automatic t_interlock;
        ctl_wr_req_i = 4'hF; #1;
        check("R10 veto multi", {12'h0, ctl_wr_grant_o}, 16'h0);
        bus_write(1'b1, 8'h10);
        ctl_wr_req_i = 4'h5; #1;
        check("R9 valid single", {15'h0, sel_valid_o}, 16'h1);
        check("R10 pass single", {12'h0, ctl_wr_grant_o}, 16'h5);
        bus_write(1'b0, 8'h01);
        ctl_wr_req_i = 4'hF; #1;
        check("R9 two regs", {15'h0, sel_valid_o}, 16'h0);
        check("R10 veto across regs", {12'h0, ctl_wr_grant_o}, 16'h0);
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'h00);
        ctl_wr_req_i = 4'hA; #1;
        check("R10 pass none", {12'h0, ctl_wr_grant_o}, 16'hA);
        check("R9 none", {15'h0, sel_valid_o}, 16'h0);
        ctl_wr_req_i = 4'h0;
    endtask

    // Load a selection, then apply one protect condition together with a write.
    task automatic t_protect(input string tag, input int which);
        bus_write(1'b1, 8'h80);
        case (which)
            0: standby_i = 1'b1;
            1: wp_pin_i = 1'b1;
            default: sw_wen_i = 1'b0;
        endcase
        bus_write(1'b0, 8'h04);
        check(tag, {4'h0, erase_permit_o}, 16'h0);
        standby_i = 1'b0; wp_pin_i = 1'b0; sw_wen_i = 1'b1;
        @(negedge clk);
        check({tag, " stays clear"}, {4'h0, erase_permit_o}, 16'h0);
    endtask

    task automatic t_flash_off;
        bus_write(1'b0, 8'h02);
        flash_en_i = 1'b0;
        read_chk("R7 lo read off", 1'b0, 8'h00);
        read_chk("R7 hi read off", 1'b1, 8'h00);
        bus_write(1'b0, 8'h08);
        bus_write(1'b1, 8'hFF);
        check("R7 write off", {4'h0, erase_permit_o}, 16'h0002);
        flash_en_i = 1'b1;
        read_chk("R7 lo after", 1'b0, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_reg();
        t_high_reg();
        t_interlock();
        t_protect("R4 standby", 0);
        t_protect("R5 wp", 1);
        t_protect("R6 swen", 2);
        t_flash_off();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset again", {4'h0, erase_permit_o}, 16'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule